// File: doc/BRIEF.md
# CAN Controller Interrupt and DMA Signal Generator

This block produces the module-level request and interrupt outputs of a CAN controller. A control register, written through a simple write port, holds the initialization bit, a module line enable, separate enables for status and error interrupts, an enable that gives message-object interrupts their own line, and one DMA enable for each of the two message interfaces.

Each interface raises its DMA request when a transfer between that interface and message RAM completes with the DMA-active command qualifier set. The request stays up until software touches any register of that interface. Status events from the protocol engine (receive OK, transmit OK, new error code, parity error, and changes of the bus-off or warning levels) set an interrupt-identifier flag when their class is enabled. A status-register read clears the flag. Pending message-object interrupts, given as a count, drive either the dedicated line or the shared status line, depending on the line enable.

Top module: `can_irq_dma_sig`

## Requirements
- R1: After reset the control register reads 0x0000_0001. Only bit 0 (init), 1 (line enable), 2 (status enable), 3 (error enable), 17 (message-object line), 18 (DMA enable, interface 0) and 19 (DMA enable, interface 1) are stored. All other bits read 0.
- R2: While the DMA enable of an interface is 0, that interface's DMA request is low. Clearing the enable drops a raised request one cycle after the register changes.
- R3: With the DMA enable set, a completion pulse with the DMA-active qualifier high raises the request on the next clock. A completion without the qualifier does not.
- R4: A raised request holds until an access strobe of its own interface and clears on the next clock. A completion with the qualifier in the same cycle as an access keeps the request high.
- R5: The two interfaces are independent. An access or completion on one interface does not change the other interface's request.
- R6: With bit 17 set, the message-object line goes high one clock after the pending count is nonzero and low one clock after the count returns to zero.
- R7: With bit 17 clear, the message-object line is low. A nonzero pending count then drives the status line only when bit 1 is set.
- R8: With the error enable set, a parity-error level of 1, or any change of the bus-off or warning level, sets the status flag on the next clock.
- R9: With the status enable set, a receive-OK, transmit-OK or new-error-code pulse sets the status flag on the next clock.
- R10: When its class enable is clear, an event does not set the status flag.
- R11: A status read clears the flag on the next clock. A set event in the same cycle wins.
- R12: The status line is low while bit 1 is 0. While bit 1 is 1, it follows the status flag in the same cycle, ORed with routed message-object interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register contents |
| xfer_done | input | 2 | Transfer-complete pulse per interface |
| xfer_dma_act | input | 2 | DMA-active qualifier per interface |
| if_acc | input | 2 | Register access strobe per interface |
| dma_req | output | 2 | DMA request per interface |
| ev_rx_ok | input | 1 | Successful receive pulse |
| ev_tx_ok | input | 1 | Successful transmit pulse |
| ev_lec_new | input | 1 | New bus error code pulse |
| par_err | input | 1 | Parity error flag level |
| bus_off | input | 1 | Bus-off level |
| err_warn | input | 1 | Error warning level |
| stat_rd | input | 1 | Status register read strobe |
| mo_pend_cnt | input | 6 | Number of pending message-object interrupts |
| irq_mo | output | 1 | Message-object interrupt line |
| irq_stat | output | 1 | Status interrupt line |
| stat_int | output | 1 | Status interrupt identifier flag |

## Verification
The hardest situations to reach are same-cycle collisions. One is an interface access arriving together with a qualified completion. The other is a status read arriving together with a new event. The stimulus drives both strobes in the same cycle and expects the set to win. Level-change detection on the bus-off and warning inputs needs the bench to hold levels across several steps. The stimulus does this, including a toggle made while the error class is disabled, followed by a later real change once it is enabled. Routing of message-object interrupts is checked across an enable rewrite. That check covers the cycle where the old register value still decides the line.

// File: rtl/can_sig_pkg.sv
package can_sig_pkg;
  localparam int CTL_W  = 32;
  localparam int NUM_IF = 2;

  localparam int B_INIT   = 0;
  localparam int B_LINE   = 1;
  localparam int B_STATIE = 2;
  localparam int B_ERRIE  = 3;
  localparam int B_MOLINE = 17;
  localparam int B_DMA0   = 18;

  localparam logic [CTL_W-1:0] CTL_RST  = 32'h0000_0001;
  localparam logic [CTL_W-1:0] CTL_MASK =
    (32'h1 << B_INIT) | (32'h1 << B_LINE) | (32'h1 << B_STATIE) |
    (32'h1 << B_ERRIE) | (32'h1 << B_MOLINE) |
    (((32'h1 << NUM_IF) - 32'h1) << B_DMA0);

  typedef struct packed {
    logic [NUM_IF-1:0] dma_en;
    logic              mo_line;
    logic              err_ie;
    logic              stat_ie;
    logic              line_en;
    logic              init;
  } ctl_t;
endpackage

// File: rtl/can_sig_ctl.sv
module can_sig_ctl
  import can_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);
  logic [CTL_W-1:0] reg_q, reg_d;

  always_comb begin
    reg_d = reg_q;
    if (wr) reg_d = wdata & CTL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= CTL_RST;
    else        reg_q <= reg_d;
  end

  always_comb begin
    ctl.init    = reg_q[B_INIT];
    ctl.line_en = reg_q[B_LINE];
    ctl.stat_ie = reg_q[B_STATIE];
    ctl.err_ie  = reg_q[B_ERRIE];
    ctl.mo_line = reg_q[B_MOLINE];
    ctl.dma_en  = reg_q[B_DMA0 +: NUM_IF];
  end

  assign rdata = reg_q;
endmodule

// File: rtl/can_sig_dma_ch.sv
module can_sig_dma_ch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic done,
  input  logic act,
  input  logic acc,
  output logic req
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (!en)             req_d = 1'b0;
    else if (done & act) req_d = 1'b1;
    else if (acc)        req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/can_sig_irq.sv
module can_sig_irq
  import can_sig_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic             ev_rx,
  input  logic             ev_tx,
  input  logic             ev_lec,
  input  logic             par_err,
  input  logic             bus_off,
  input  logic             err_warn,
  input  logic             stat_rd,
  input  logic [CNT_W-1:0] mo_cnt,
  output logic             irq_mo,
  output logic             irq_stat,
  output logic             flag
);
  logic bo_prev_q, ew_prev_q;
  logic flag_q, flag_d;
  logic mo_q, mo_d;
  logic st_q, st_d;
  logic err_hit, st_hit, set_ev, mo_any;

  always_comb begin
    err_hit = par_err | (bus_off ^ bo_prev_q) | (err_warn ^ ew_prev_q);
    st_hit  = ev_rx | ev_tx | ev_lec;
    set_ev  = (ctl.err_ie & err_hit) | (ctl.stat_ie & st_hit);
    flag_d  = set_ev | (flag_q & ~stat_rd);
    mo_any  = |mo_cnt;
    mo_d    = ctl.mo_line & mo_any;
    st_d    = ctl.line_en & (flag_d | (~ctl.mo_line & mo_any));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_prev_q <= 1'b0;
      ew_prev_q <= 1'b0;
      flag_q    <= 1'b0;
      mo_q      <= 1'b0;
      st_q      <= 1'b0;
    end else begin
      bo_prev_q <= bus_off;
      ew_prev_q <= err_warn;
      flag_q    <= flag_d;
      mo_q      <= mo_d;
      st_q      <= st_d;
    end
  end

  assign irq_mo   = mo_q;
  assign irq_stat = st_q;
  assign flag     = flag_q;
endmodule

// File: rtl/can_irq_dma_sig.sv
module can_irq_dma_sig
  import can_sig_pkg::*;
#(
  parameter int MO_CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [CTL_W-1:0]    ctl_wdata,
  output logic [CTL_W-1:0]    ctl_rdata,
  input  logic [NUM_IF-1:0]   xfer_done,
  input  logic [NUM_IF-1:0]   xfer_dma_act,
  input  logic [NUM_IF-1:0]   if_acc,
  output logic [NUM_IF-1:0]   dma_req,
  input  logic                ev_rx_ok,
  input  logic                ev_tx_ok,
  input  logic                ev_lec_new,
  input  logic                par_err,
  input  logic                bus_off,
  input  logic                err_warn,
  input  logic                stat_rd,
  input  logic [MO_CNT_W-1:0] mo_pend_cnt,
  output logic                irq_mo,
  output logic                irq_stat,
  output logic                stat_int
);
  ctl_t ctl;

  can_sig_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl   (ctl),
    .rdata (ctl_rdata)
  );

  for (genvar i = 0; i < NUM_IF; i++) begin : g_dma
    can_sig_dma_ch u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctl.dma_en[i]),
      .done  (xfer_done[i]),
      .act   (xfer_dma_act[i]),
      .acc   (if_acc[i]),
      .req   (dma_req[i])
    );
  end

  can_sig_irq #(.CNT_W(MO_CNT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .ev_rx    (ev_rx_ok),
    .ev_tx    (ev_tx_ok),
    .ev_lec   (ev_lec_new),
    .par_err  (par_err),
    .bus_off  (bus_off),
    .err_warn (err_warn),
    .stat_rd  (stat_rd),
    .mo_cnt   (mo_pend_cnt),
    .irq_mo   (irq_mo),
    .irq_stat (irq_stat),
    .flag     (stat_int)
  );
endmodule

// File: rtl/can_sig_chk.sv
module can_sig_chk
  import can_sig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTL_W-1:0]  ctl_rdata,
  input logic [NUM_IF-1:0] xfer_done,
  input logic [NUM_IF-1:0] xfer_dma_act,
  input logic [NUM_IF-1:0] if_acc,
  input logic [NUM_IF-1:0] dma_req,
  input logic              stat_rd,
  input logic              irq_mo,
  input logic              irq_stat,
  input logic              stat_int
);
  for (genvar i = 0; i < NUM_IF; i++) begin : g_chk
    assert_dma_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[B_DMA0+i] |=> !dma_req[i]);
    assert_dma_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[B_DMA0+i] && xfer_done[i] && xfer_dma_act[i] |=> dma_req[i]);
    assert_dma_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[i] && ctl_rdata[B_DMA0+i] && !if_acc[i] |=> dma_req[i]);
    assert_dma_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[i] && if_acc[i] && !(xfer_done[i] && xfer_dma_act[i]) |=> !dma_req[i]);
  end

  assert_mo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[B_MOLINE] |=> !irq_mo);
  assert_stat_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[B_LINE] |=> !irq_stat);
  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_int && !stat_rd |=> stat_int);
  assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[B_STATIE] && !ctl_rdata[B_ERRIE] && !stat_int |=> !stat_int);
  assert_flag_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[B_LINE] && ctl_rdata[B_MOLINE] |=> (irq_stat == stat_int));
endmodule

bind can_irq_dma_sig can_sig_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_rdata    (ctl_rdata),
  .xfer_done    (xfer_done),
  .xfer_dma_act (xfer_dma_act),
  .if_acc       (if_acc),
  .dma_req      (dma_req),
  .stat_rd      (stat_rd),
  .irq_mo       (irq_mo),
  .irq_stat     (irq_stat),
  .stat_int     (stat_int)
);

// File: tb/sim_can_irq_dma_sig.sv
module sim_can_irq_dma_sig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic [1:0]  xfer_done = '0, xfer_dma_act = '0, if_acc = '0, dma_req;
  logic        ev_rx_ok = 0, ev_tx_ok = 0, ev_lec_new = 0;
  logic        par_err = 0, bus_off = 0, err_warn = 0, stat_rd = 0;
  logic [5:0]  mo_pend_cnt = '0;
  logic        irq_mo, irq_stat, stat_int;

  always #5 clk = ~clk;

  can_irq_dma_sig u0 (.*);

  typedef struct {
    string       tag;
    logic [31:0] ctl;
    logic [1:0]  dma;
    logic        mo, st, fl;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit fin = 0;
  logic [31:0] e_ctl = 32'h1;
  logic [1:0]  e_dma = 2'b00;
  logic        e_mo = 0, e_st = 0, e_fl = 0;

  // monitor: compares outputs between edges
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (ctl_rdata !== it.ctl || dma_req !== it.dma || irq_mo !== it.mo ||
          irq_stat !== it.st || stat_int !== it.fl) begin
        errors++;
        $display("FAIL %s got ctl=%h dma=%b mo=%b st=%b fl=%b exp ctl=%h dma=%b mo=%b st=%b fl=%b",
                 it.tag, ctl_rdata, dma_req, irq_mo, irq_stat, stat_int,
                 it.ctl, it.dma, it.mo, it.st, it.fl);
      end
    end
  end

  // driver: one clock, then queue the expectation, then drop pulses
  task automatic tick(input string tag);
    exp_t it;
    @(posedge clk);
    it.tag = tag; it.ctl = e_ctl; it.dma = e_dma;
    it.mo = e_mo; it.st = e_st; it.fl = e_fl;
    sb.push_back(it);
    @(negedge clk);
    ctl_wr = 0; xfer_done = '0; xfer_dma_act = '0; if_acc = '0;
    ev_rx_ok = 0; ev_tx_ok = 0; ev_lec_new = 0; stat_rd = 0;
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_wr = 1; ctl_wdata = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R1");
    // R2: disabled interfaces ignore completions
    xfer_done = 2'b11; xfer_dma_act = 2'b11; tick("R2");
    wr_ctl(32'hFFF0_0000 | 32'h000C_0000); e_ctl = 32'h000C_0000; tick("R1");
    // R3
    xfer_done = 2'b01; tick("R3");
    xfer_done = 2'b01; xfer_dma_act = 2'b01; e_dma = 2'b01; tick("R3");
    // R5 / R4
    if_acc = 2'b10; tick("R5");
    tick("R4");
    if_acc = 2'b01; e_dma = 2'b00; tick("R4");
    xfer_done = 2'b10; xfer_dma_act = 2'b10; e_dma = 2'b10; tick("R5");
    if_acc = 2'b10; xfer_done = 2'b10; xfer_dma_act = 2'b10; tick("R4");
    if_acc = 2'b10; e_dma = 2'b00; tick("R4");
    // R2: clearing the enable drops the request
    xfer_done = 2'b01; xfer_dma_act = 2'b01; e_dma = 2'b01; tick("R3");
    wr_ctl(32'h0008_0000); e_ctl = 32'h0008_0000; tick("R2");
    e_dma = 2'b00; tick("R2");
    // R6
    wr_ctl(32'h0002_0000); e_ctl = 32'h0002_0000; tick("R6");
    mo_pend_cnt = 3; e_mo = 1; tick("R6");
    mo_pend_cnt = 1; tick("R6");
    mo_pend_cnt = 0; e_mo = 0; tick("R6");
    // R7
    mo_pend_cnt = 2; wr_ctl(32'h2); e_ctl = 32'h2; e_mo = 1; tick("R6");
    e_mo = 0; e_st = 1; tick("R7");
    mo_pend_cnt = 0; e_st = 0; tick("R7");
    mo_pend_cnt = 2; wr_ctl(32'h0); e_ctl = 32'h0; e_st = 1; tick("R7");
    e_st = 0; tick("R7");
    mo_pend_cnt = 0; tick("R7");
    // R10: all classes disabled
    ev_rx_ok = 1; ev_tx_ok = 1; ev_lec_new = 1; par_err = 1; bus_off = 1; tick("R10");
    par_err = 0; tick("R10");
    // R9 / R11 / R12
    wr_ctl(32'h6); e_ctl = 32'h6; tick("R1");
    ev_rx_ok = 1; e_fl = 1; e_st = 1; tick("R9");
    tick("R11");
    stat_rd = 1; e_fl = 0; e_st = 0; tick("R11");
    ev_tx_ok = 1; e_fl = 1; e_st = 1; tick("R9");
    stat_rd = 1; ev_lec_new = 1; tick("R11");
    stat_rd = 1; e_fl = 0; e_st = 0; tick("R11");
    wr_ctl(32'h4); e_ctl = 32'h4; tick("R12");
    ev_rx_ok = 1; e_fl = 1; tick("R12");
    stat_rd = 1; e_fl = 0; tick("R11");
    // R8
    wr_ctl(32'hA); e_ctl = 32'hA; tick("R8");
    err_warn = 1; e_fl = 1; e_st = 1; tick("R8");
    stat_rd = 1; e_fl = 0; e_st = 0; tick("R8");
    bus_off = 0; e_fl = 1; e_st = 1; tick("R8");
    stat_rd = 1; e_fl = 0; e_st = 0; tick("R11");
    par_err = 1; e_fl = 1; e_st = 1; tick("R8");
    stat_rd = 1; tick("R8");
    par_err = 0; stat_rd = 1; e_fl = 0; e_st = 0; tick("R11");
    ev_rx_ok = 1; tick("R10");
    @(negedge clk);
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule